// File: doc/BRIEF.md
# Tile Semaphore Lock Bank

This block holds sixteen binary semaphores for one compute tile. Each semaphore has an "acquired" flag and a one-bit value. The tile's core, its DMA engine and neighbouring cores use these semaphores to hand local buffers back and forth. The semaphores do not guard the memory in hardware. They are a protocol that the users agree to follow. A user claims a semaphore by acquiring it with the value it expects to see, does its work on the buffer, and then releases it with whichever value the next user should wait for. This lets a producer and a consumer alternate on a buffer, which a plain mutex cannot do.

The block has four requester ports. Each port presents a valid bit, a 4-bit lock index, an operation bit and a value bit. The answer comes back one clock later as one of three pulses:
- grant: the operation succeeded.
- retry: the requester must try again.
- error: it released a lock that was not held.

When several ports target the same lock in one cycle, the lowest-numbered port wins. A debug port shows the acquired flags and the values of all sixteen locks at all times.

Top module: `sema_bank`

## Requirements
- R1: The bank holds 16 independent locks, selected by a 4-bit index. Bit n of `dbg_held` and of `dbg_value` shows lock n.
- R2: After reset every lock is not held and has value 0. No response outputs are active.
- R3: An acquire (`req_rel` bit = 0) is granted only when the lock is not held and its value equals the request's value bit. The lock then becomes held and its value is unchanged.
- R4: An acquire that does not meet R3 produces a retry and leaves the lock unchanged. Examples are an acquire of a held lock, or an acquire whose value bit differs from the stored value.
- R5: A release (`req_rel` bit = 1) of a held lock is granted. The lock becomes not held and its value becomes the request's value bit, whatever value was used to acquire it.
- R6: A release of a lock that is not held is ignored. The lock's flag and value stay the same, the port gets a one-cycle error pulse, and it gets no grant.
- R7: When several ports address the same lock in one cycle, the lowest-numbered port is served. Every other port on that lock gets a retry, and its operation has no effect.
- R8: Requests to different locks in the same cycle are each served independently.
- R9: A valid request on a port produces exactly one of grant, retry or error on that port one clock later. A port with no request produces none.
- R10: The new lock state appears on the debug outputs in the same cycle as the response that reports the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 4 | Request present, one bit per port (port 0 has the highest priority) |
| req_idx | input | 16 | Lock index, 4 bits per port; port p uses bits [4p+3:4p] |
| req_rel | input | 4 | Operation per port: 0 = acquire, 1 = release |
| req_val | input | 4 | Value per port: the value to match on acquire, or the value to store on release |
| rsp_grant | output | 4 | Operation succeeded, one cycle after the request |
| rsp_retry | output | 4 | Acquire refused or port lost arbitration; try again |
| rsp_err | output | 4 | Release of a lock that was not held |
| dbg_held | output | 16 | Acquired flag of every lock |
| dbg_value | output | 16 | Stored value of every lock |

## Verification
The assertions assume that the request inputs are steady at the clock edge and that `req_idx` always addresses an existing lock. With sixteen locks and a 4-bit field, every index is in range. The assertions also assume that any port may release any lock, because the bank does not record which port owns a lock. The stimulus is driven only on falling edges, so it always meets these assumptions. The random phase packs the indices of all ports into a few locks, so that contention, releases of free locks and mismatched acquires all occur often.

// File: rtl/sema_pkg.sv
package sema_pkg;

  typedef enum logic {
    OP_ACQ = 1'b0,
    OP_REL = 1'b1
  } sema_op_e;

  // Acquire succeeds on a free lock whose value matches.
  function automatic logic acq_ok(input logic held, input logic cur, input logic want);
    return !held && (cur == want);
  endfunction

  // Release succeeds only on a held lock.
  function automatic logic rel_ok(input logic held);
    return held;
  endfunction

endpackage

// File: rtl/sema_arbiter.sv
module sema_arbiter #(
  parameter int NP = 4,
  parameter int IW = 4
) (
  input  logic [NP-1:0]    valid,
  input  logic [NP*IW-1:0] idx,
  output logic [NP-1:0]    win
);

  // A port wins unless a lower-numbered valid port addresses the same lock.
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      win[p] = valid[p];
      for (int q = 0; q < p; q++) begin
        if (valid[q] && (idx[q*IW +: IW] == idx[p*IW +: IW])) win[p] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/sema_lock_cell.sv
module sema_lock_cell
  import sema_pkg::*;
#(
  parameter int NP = 4,
  parameter int IW = 4,
  parameter int ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    win,
  input  logic [NP*IW-1:0] idx,
  input  logic [NP-1:0]    rel,
  input  logic [NP-1:0]    val,
  output logic             held,
  output logic             value
);

  logic hit;
  logic hit_rel;
  logic hit_val;

  // At most one winning port addresses this lock.
  always_comb begin
    hit     = 1'b0;
    hit_rel = 1'b0;
    hit_val = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (win[p] && (idx[p*IW +: IW] == IW'(ID))) begin
        hit     = 1'b1;
        hit_rel = rel[p];
        hit_val = val[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= 1'b0;
      value <= 1'b0;
    end else if (hit) begin
      if (sema_op_e'(hit_rel) == OP_ACQ) begin
        if (acq_ok(held, value, hit_val)) held <= 1'b1;
      end else if (rel_ok(held)) begin
        held  <= 1'b0;
        value <= hit_val;
      end
    end
  end

endmodule

// File: rtl/sema_resp.sv
module sema_resp
  import sema_pkg::*;
#(
  parameter int NP = 4,
  parameter int NL = 16,
  parameter int IW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    valid,
  input  logic [NP-1:0]    win,
  input  logic [NP*IW-1:0] idx,
  input  logic [NP-1:0]    rel,
  input  logic [NP-1:0]    val,
  input  logic [NL-1:0]    held_vec,
  input  logic [NL-1:0]    value_vec,
  output logic [NP-1:0]    grant,
  output logic [NP-1:0]    retry,
  output logic [NP-1:0]    err
);

  logic [NP-1:0] grant_d;
  logic [NP-1:0] err_d;
  logic [NP-1:0] retry_d;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      logic h;
      logic v;
      h = held_vec[idx[p*IW +: IW]];
      v = value_vec[idx[p*IW +: IW]];
      if (sema_op_e'(rel[p]) == OP_REL) begin
        grant_d[p] = win[p] && rel_ok(h);
        err_d[p]   = win[p] && !rel_ok(h);
      end else begin
        grant_d[p] = win[p] && acq_ok(h, v, val[p]);
        err_d[p]   = 1'b0;
      end
      retry_d[p] = valid[p] && !grant_d[p] && !err_d[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant <= '0;
      retry <= '0;
      err   <= '0;
    end else begin
      grant <= grant_d;
      retry <= retry_d;
      err   <= err_d;
    end
  end

endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
  parameter int NP = 4,
  parameter int NL = 16,
  localparam int IW = $clog2(NL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    req_valid,
  input  logic [NP*IW-1:0] req_idx,
  input  logic [NP-1:0]    req_rel,
  input  logic [NP-1:0]    req_val,
  output logic [NP-1:0]    rsp_grant,
  output logic [NP-1:0]    rsp_retry,
  output logic [NP-1:0]    rsp_err,
  output logic [NL-1:0]    dbg_held,
  output logic [NL-1:0]    dbg_value
);

  logic [NP-1:0] port_win;
  logic [NL-1:0] lock_held;
  logic [NL-1:0] lock_value;

  sema_arbiter #(.NP(NP), .IW(IW)) u_arb (
    .valid (req_valid),
    .idx   (req_idx),
    .win   (port_win)
  );

  for (genvar l = 0; l < NL; l++) begin : g_lock
    sema_lock_cell #(.NP(NP), .IW(IW), .ID(l)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .win   (port_win),
      .idx   (req_idx),
      .rel   (req_rel),
      .val   (req_val),
      .held  (lock_held[l]),
      .value (lock_value[l])
    );
  end

  sema_resp #(.NP(NP), .NL(NL), .IW(IW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (req_valid),
    .win       (port_win),
    .idx       (req_idx),
    .rel       (req_rel),
    .val       (req_val),
    .held_vec  (lock_held),
    .value_vec (lock_value),
    .grant     (rsp_grant),
    .retry     (rsp_retry),
    .err       (rsp_err)
  );

  assign dbg_held  = lock_held;
  assign dbg_value = lock_value;

endmodule

// File: rtl/sema_bank_chk.sv
module sema_bank_chk #(
  parameter int NP = 4,
  parameter int NL = 16,
  parameter int IW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NP-1:0]    req_valid,
  input logic [NP*IW-1:0] req_idx,
  input logic [NP-1:0]    req_rel,
  input logic [NP-1:0]    req_val,
  input logic [NP-1:0]    rsp_grant,
  input logic [NP-1:0]    rsp_retry,
  input logic [NP-1:0]    rsp_err,
  input logic [NL-1:0]    dbg_held,
  input logic [NL-1:0]    dbg_value
);

  logic [IW-1:0] last_idx [NP];
  logic [NP-1:0] last_rel;
  logic [NP-1:0] last_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) last_idx[p] <= '0;
      last_rel <= '0;
      last_val <= '0;
    end else begin
      for (int p = 0; p < NP; p++) last_idx[p] <= req_idx[p*IW +: IW];
      last_rel <= req_rel;
      last_val <= req_val;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_grant[p], rsp_retry[p], rsp_err[p]})); // R9
    AST_ANSWER_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[p] |=> (rsp_grant[p] || rsp_retry[p] || rsp_err[p])); // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[p] |=> !(rsp_grant[p] || rsp_retry[p] || rsp_err[p])); // R9
    AST_ACQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_grant[p] && !last_rel[p]) |-> dbg_held[last_idx[p]]); // R3
    AST_REL_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_grant[p] && last_rel[p]) |->
        (!dbg_held[last_idx[p]] && (dbg_value[last_idx[p]] == last_val[p]))); // R5
    AST_ERR_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err[p] |-> (last_rel[p] && !dbg_held[last_idx[p]])); // R6
    for (genvar q = 0; q < p; q++) begin : g_hi
      AST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[p] && req_valid[q] && (req_idx[p*IW +: IW] == req_idx[q*IW +: IW]))
          |=> (rsp_retry[p] && !rsp_grant[p])); // R7
    end
  end

endmodule

bind sema_bank sema_bank_chk #(.NP(NP), .NL(NL), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_idx   (req_idx),
  .req_rel   (req_rel),
  .req_val   (req_val),
  .rsp_grant (rsp_grant),
  .rsp_retry (rsp_retry),
  .rsp_err   (rsp_err),
  .dbg_held  (dbg_held),
  .dbg_value (dbg_value)
);

// File: tb/test_sema_bank.sv
module test_sema_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req_valid = '0;
  logic [15:0] req_idx = '0;
  logic [3:0]  req_rel = '0;
  logic [3:0]  req_val = '0;
  logic [3:0]  rsp_grant, rsp_retry, rsp_err;
  logic [15:0] dbg_held, dbg_value;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  logic [15:0] m_held = '0;
  logic [15:0] m_val = '0;

  always #4 clk = ~clk;

  sema_bank i_sema_bank (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_idx(req_idx), .req_rel(req_rel), .req_val(req_val),
    .rsp_grant(rsp_grant), .rsp_retry(rsp_retry), .rsp_err(rsp_err),
    .dbg_held(dbg_held), .dbg_value(dbg_value)
  );

  // Apply one cycle of requests, predict, and compare one clock later.
  task automatic step(input logic [3:0] v, input logic [3:0] r, input logic [3:0] d,
                      input logic [15:0] ix, input string tag);
    logic [3:0]  eg, er, ee;
    logic [15:0] claimed;
    eg = '0; er = '0; ee = '0; claimed = '0;
    req_valid = v; req_rel = r; req_val = d; req_idx = ix;
    for (int p = 0; p < 4; p++) begin
      int k;
      k = int'(ix[p*4 +: 4]);
      if (v[p]) begin
        if (claimed[k]) er[p] = 1'b1;
        else begin
          claimed[k] = 1'b1;
          if (r[p]) begin
            if (m_held[k]) begin eg[p] = 1'b1; m_held[k] = 1'b0; m_val[k] = d[p]; end
            else ee[p] = 1'b1;
          end else if (!m_held[k] && (m_val[k] == d[p])) begin
            eg[p] = 1'b1; m_held[k] = 1'b1;
          end else er[p] = 1'b1;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (rsp_grant !== eg || rsp_retry !== er || rsp_err !== ee) begin
      misses++;
      $display("FAIL %s responses got g=%b r=%b e=%b expected g=%b r=%b e=%b",
               tag, rsp_grant, rsp_retry, rsp_err, eg, er, ee);
    end else if (dbg_held !== m_held || dbg_value !== m_val) begin
      misses++;
      $display("FAIL %s R10 lock state got held=%h val=%h expected held=%h val=%h",
               tag, dbg_held, dbg_value, m_held, m_val);
    end
  endtask

  function automatic logic [15:0] rep(input logic [3:0] k);
    return {k, k, k, k};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    vectors++;
    if (dbg_held !== 16'h0 || dbg_value !== 16'h0 || (rsp_grant | rsp_retry | rsp_err) !== 4'h0) begin
      misses++;
      $display("FAIL R2 reset got held=%h val=%h rsp=%b expected 0 0 0",
               dbg_held, dbg_value, rsp_grant | rsp_retry | rsp_err);
    end
    rst_n = 1'b1;

    // R1 R3 R4 R5 R6: single-port sweep over every lock and every port
    for (int p = 0; p < 4; p++) begin
      for (int l = 0; l < 16; l++) begin
        logic [3:0] one;
        one = 4'b0001 << p;
        step(one, 4'h0, 4'h0 & one, rep(4'(l)), "R3");  // acquire 0 on fresh lock
        step(one, 4'h0, 4'hF & one, rep(4'(l)), "R4");  // held -> retry
        step(one, 4'hF & one, 4'hF & one, rep(4'(l)), "R5"); // release with 1
        step(one, 4'hF & one, 4'h0, rep(4'(l)), "R6");  // free -> error
        step(one, 4'h0, 4'h0, rep(4'(l)), "R4");        // value mismatch
        step(one, 4'h0, 4'hF & one, rep(4'(l)), "R3");  // acquire 1
        step(one, 4'hF & one, 4'h0, rep(4'(l)), "R5");  // release back to 0
        step(4'h0, 4'h0, 4'h0, 16'h0, "R9");            // idle
      end
    end
    // R1: sweep of every lock left all free with value 0
    vectors++;
    if (dbg_held !== 16'h0 || dbg_value !== 16'h0) begin
      misses++;
      $display("FAIL R1 after sweep got held=%h val=%h expected 0 0", dbg_held, dbg_value);
    end

    // R7: all ports on one lock with mixed operations
    for (int c = 0; c < 16; c++) begin
      step(4'hF, 4'(c), 4'(c * 5), rep(4'(c)), "R7");
    end
    // R8: four distinct locks at once
    for (int c = 0; c < 16; c++) begin
      step(4'hF, 4'(c), 4'(c ^ 3), {4'(c), 4'(c + 4), 4'(c + 8), 4'(c + 12)}, "R8");
    end
    // R9 and mixed behaviour under heavy contention
    for (int c = 0; c < 4000; c++) begin
      logic [15:0] ix;
      ix = 16'($urandom) & ((c % 3 == 0) ? 16'hFFFF : 16'h3333);
      step(4'($urandom), 4'($urandom), 4'($urandom), ix, "R9");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule